// File: doc/BRIEF.md
# Pin Bank Controller with Change Interrupts

This block controls a bank of 24 general-purpose pins through six 32-bit registers on a small register bus. Software sets each pin as an input or an output. An output either drives both levels or, in open-drain mode, only pulls low and otherwise releases the pin. The pin inputs may change at any time with no relation to the clock. Each one passes through a two-stage synchroniser, then an edge detector watches it. When a pin changes level it sets a sticky event bit. That bit can be set to respond to either edge or to the falling edge only.

Software clears event bits by writing ones to them. A mask selects which events drive the single interrupt output, and that output is the OR of the masked events. The register window is 24 bytes long. Offsets past the last register read as zero and ignore writes. The bus is a plain control path with no back-pressure. A write is accepted in the cycle it is presented. A read returns its data one cycle later, marked by a valid strobe.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the direction, open-drain, data, event and mask registers read as zero, `pin_oe` is all zero and `irq` is low.
- R2: The register order is fixed by the word index `bus_addr[4:2]`:
  - 0 direction (1 = output)
  - 1 open-drain enable
  - 2 data
  - 3 event
  - 4 mask
  - 5 edge control
  
  A write takes effect at the clock edge where `bus_sel && bus_wr` is sampled. A read sampled at an edge returns `rd_data` with `rd_valid` high in the cycle after that edge.
- R3: Byte offsets 0x18 to 0x1F read as zero, and a write to them changes no register.
- R4: Register bits 31:24 always read as zero.
- R5: When a pin is an output with open-drain off, `pin_oe` is 1 and `pin_out` follows the data latch. When a pin is an input, `pin_oe` is 0.
- R6: When a pin is an output with open-drain on, `pin_out` is 0 and `pin_oe` is the inverse of the data latch, so the pin is never driven high.
- R7: A data register read returns the output latch for output pins and the synchronised input level for input pins.
- R8: Consider a level change on `pin_in` that is first sampled at clock edge k. That change is seen by a data read sampled at edge k+2, and its event bit sets at edge k+2. Before then neither shows it.
- R9: Edge control bit 0 makes the pin's event fire on either edge. Bit 1 makes it fire on a falling edge only, so a rising edge is ignored.
- R10: An event bit stays set until a write of 1 to that bit of the event register. Writing 0 leaves the bit unchanged.
- R11: If an edge sets an event bit in the same cycle that a write-one-to-clear targets it, the bit ends set.
- R12: `irq` is high exactly while some bit of (event AND mask) is 1, in the same cycle the event bit becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | High for one cycle when rd_data holds a read result |
| pin_in | input | 24 | Asynchronous pin levels |
| pin_out | output | 24 | Level to drive on each pin |
| pin_oe | output | 24 | Drive enable per pin |
| irq | output | 1 | Masked change interrupt |

## Verification
Register writes show at the pins right after the edge that samples them. Read data is checked one cycle after the read is sampled. A pin change waits two synchroniser stages and one edge-detect stage, so its event and readback are due at the third edge that sees it. The bench drives every input at the falling clock edge and samples at the falling edge too. Random rounds let the pins settle for four cycles before checking. Directed cases count exact edges to show that nothing arrives early in the R8 latency test and that a clear landing on the setting edge loses to the set.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    REG_DIR  = 3'd0,
    REG_OD   = 3'd1,
    REG_DAT  = 3'd2,
    REG_EVT  = 3'd3,
    REG_MSK  = 3'd4,
    REG_CTL  = 3'd5,
    REG_NONE = 3'd7
  } reg_sel_e;

  localparam int unsigned NUM_REGS = 6;

  function automatic reg_sel_e decode_word(input logic [2:0] word_idx);
    reg_sel_e r;
    if (word_idx < 3'(NUM_REGS)) r = reg_sel_e'(word_idx);
    else                         r = REG_NONE;
    return r;
  endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int NPIN   = 24,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] async_in,
  output logic [NPIN-1:0] sync_out
);

  logic [NPIN-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
  parameter int NPIN = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] level,
  input  logic [NPIN-1:0] fall_only,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] evt
);

  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] hit;
  logic [NPIN-1:0] evt_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  genvar i;
  generate
    for (i = 0; i < NPIN; i++) begin : g_det
      logic rise_i, fall_i;
      assign rise_i = level[i] & ~prev_q[i];
      assign fall_i = ~level[i] & prev_q[i];
      assign hit[i] = fall_only[i] ? fall_i : (rise_i | fall_i);
    end
  endgenerate

  // set has priority over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= (evt_q & ~clr) | hit;
  end

  assign evt = evt_q;

  assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evt & $past(clr & ~hit)) == '0));

  assert_event_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(evt & ~clr) & ~evt) == '0));

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(hit) & ~evt) == '0));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 24,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  input  logic [NPIN-1:0] sync_lvl,
  input  logic [NPIN-1:0] evt,
  output logic [NPIN-1:0] dir,
  output logic [NPIN-1:0] od,
  output logic [NPIN-1:0] latch,
  output logic [NPIN-1:0] mask,
  output logic [NPIN-1:0] fall_only,
  output logic [NPIN-1:0] evt_clr
);

  localparam int PAD = DW - NPIN;

  reg_sel_e        sel;
  logic            wr_en, rd_en;
  logic [NPIN-1:0] wbits;
  logic [NPIN-1:0] rd_mux;
  logic            unused_bus;

  assign sel   = decode_word(bus_addr[4:2]);
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;
  assign wbits = bus_wdata[NPIN-1:0];
  assign unused_bus = ^{bus_wdata[DW-1:NPIN], bus_addr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      dir       <= '0;
      od        <= '0;
      latch     <= '0;
      mask      <= '0;
      fall_only <= '0;
    end else if (wr_en) begin
      unique case (sel)
        REG_DIR: dir       <= wbits;
        REG_OD:  od        <= wbits;
        REG_DAT: latch     <= wbits;
        REG_MSK: mask      <= wbits;
        REG_CTL: fall_only <= wbits;
        default: ;
      endcase
    end
  end

  assign evt_clr = (wr_en && sel == REG_EVT) ? wbits : '0;

  always_comb begin
    unique case (sel)
      REG_DIR: rd_mux = dir;
      REG_OD:  rd_mux = od;
      REG_DAT: rd_mux = (dir & latch) | (~dir & sync_lvl);
      REG_EVT: rd_mux = evt;
      REG_MSK: rd_mux = mask;
      REG_CTL: rd_mux = fall_only;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= {{PAD{1'b0}}, rd_mux};
    end
  end

  assert_unmapped_rd_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr >= AW'(4 * NUM_REGS)) |=> (rd_data == '0));

  assert_rd_valid_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_unmapped_wr_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_addr >= AW'(4 * NUM_REGS)) |=>
      ($stable(dir) && $stable(od) && $stable(latch) && $stable(mask) && $stable(fall_only)));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPIN   = 24,
  parameter int AW     = 5,
  parameter int DW     = 32,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);

  logic [NPIN-1:0] sync_lvl, evt, dir, od, latch, mask, fall_only, evt_clr;

  gpio_bank_sync #(.NPIN(NPIN), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(sync_lvl)
  );

  gpio_bank_edge #(.NPIN(NPIN)) u_edge (
    .clk(clk), .rst(rst), .level(sync_lvl), .fall_only(fall_only),
    .clr(evt_clr), .evt(evt)
  );

  gpio_bank_regs #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .sync_lvl(sync_lvl), .evt(evt), .dir(dir),
    .od(od), .latch(latch), .mask(mask), .fall_only(fall_only),
    .evt_clr(evt_clr)
  );

  genvar i;
  generate
    for (i = 0; i < NPIN; i++) begin : g_drv
      always_comb begin
        if (od[i]) begin
          pin_out[i] = 1'b0;
          pin_oe[i]  = dir[i] & ~latch[i];
        end else begin
          pin_out[i] = latch[i];
          pin_oe[i]  = dir[i];
        end
      end
    end
  endgenerate

  assign irq = |(evt & mask);

  assert_od_never_high_R6: assert property (@(posedge clk) disable iff (rst)
    ((pin_oe & pin_out & od) == '0));

  assert_input_undriven_R5: assert property (@(posedge clk) disable iff (rst)
    ((pin_oe & ~dir) == '0));

endmodule

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [23:0] pin_in, pin_out, pin_oe;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [23:0] exp_oe(input logic [23:0] dr, od, dt);
    return (dr & ~od) | (dr & od & ~dt);
  endfunction

  function automatic logic [23:0] exp_out(input logic [23:0] od, dt);
    return dt & ~od;
  endfunction

  function automatic logic [23:0] exp_hit(input logic [23:0] o, n, ctl);
    return (o ^ n) & (~ctl | ~n);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [23:0] dr, od, dt, mk, ct, pins, npins, ev, c;
    void'($urandom(32'd2718));
    rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 oe", {8'h0, pin_oe}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    for (int a = 0; a < 5; a++) begin
      rd(5'(4 * a), v);
      chk("R1 reg", v, 32'h0);
    end

    // R2 register order and read strobe; R4 upper bits
    wr(5'h00, 32'hFF_A5A5A5); wr(5'h04, 32'h00_0F0F0F); wr(5'h08, 32'h00_123456);
    wr(5'h10, 32'h00_00F000); wr(5'h14, 32'h00_ABCDEF);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h00;
    @(negedge clk); bus_sel = 1'b0;
    chk("R2 rd_valid", {31'h0, rd_valid}, 32'h1);
    chk("R4 upper zero dir", rd_data, 32'h00_A5A5A5);
    @(negedge clk);
    chk("R2 rd_valid low", {31'h0, rd_valid}, 32'h0);
    rd(5'h04, v); chk("R2 od", v, 32'h000F0F0F);
    rd(5'h10, v); chk("R2 mask", v, 32'h0000F000);
    rd(5'h14, v); chk("R2 ctl", v, 32'h00ABCDEF);

    // R3 unmapped window
    wr(5'h18, 32'hFFFFFFFF); wr(5'h1C, 32'hFFFFFFFF);
    rd(5'h18, v); chk("R3 rd 0x18", v, 32'h0);
    rd(5'h1C, v); chk("R3 rd 0x1C", v, 32'h0);
    rd(5'h00, v); chk("R3 dir kept", v, 32'h00A5A5A5);
    rd(5'h14, v); chk("R3 ctl kept", v, 32'h00ABCDEF);

    // R8/R12 latency: pin 3 any-edge, masked
    wr(5'h00, 32'h0); wr(5'h04, 32'h0); wr(5'h08, 32'h0);
    wr(5'h14, 32'h0); wr(5'h10, 32'h8);
    pin_in = 24'h8;                 // first sampled at edge k
    @(negedge clk); @(negedge clk); // after k, k+1
    chk("R8 no event early", {31'h0, irq}, 32'h0);
    @(negedge clk);                 // after k+2
    chk("R8 R12 irq on time", {31'h0, irq}, 32'h1);
    rd(5'h08, v); chk("R7 input level", v, 32'h8);
    wr(5'h0C, 32'h0); rd(5'h0C, v); chk("R10 write0 keeps", v, 32'h8);
    wr(5'h0C, 32'h8); rd(5'h0C, v); chk("R10 w1c clears", v, 32'h0);
    chk("R12 irq drop", {31'h0, irq}, 32'h0);

    // R11 set wins: clear lands on the setting edge
    pin_in = 24'h0;
    @(negedge clk); @(negedge clk);
    wr(5'h0C, 32'h8);               // sampled at edge k+2
    rd(5'h0C, v); chk("R11 set wins", v, 32'h8);
    wr(5'h0C, 32'h8);

    // R9 falling only on pin 5
    wr(5'h14, 32'h20); wr(5'h10, 32'h20);
    pin_in = 24'h20; repeat (4) @(negedge clk);
    chk("R9 rise ignored", {31'h0, irq}, 32'h0);
    pin_in = 24'h0; repeat (4) @(negedge clk);
    chk("R9 fall fires", {31'h0, irq}, 32'h1);
    wr(5'h0C, 32'hFFFFFF);

    // R5 R6 drive modes
    wr(5'h00, 32'h0F); wr(5'h04, 32'h0C); wr(5'h08, 32'h05);
    chk("R5 R6 oe", {8'h0, pin_oe}, 32'h0000000B);
    chk("R5 R6 out", {8'h0, pin_out}, 32'h00000001);

    // random rounds
    pins = 24'h0; ev = 24'h0;
    for (int it = 0; it < 150; it++) begin
      dr = 24'($urandom); od = 24'($urandom); dt = 24'($urandom);
      mk = 24'($urandom); ct = 24'($urandom);
      if (it % 7 == 0) dr = 24'h0;
      wr(5'h00, {8'hFF, dr}); wr(5'h04, {8'h0, od}); wr(5'h08, {8'h0, dt});
      wr(5'h10, {8'h0, mk}); wr(5'h14, {8'h0, ct});
      chk("R5 R6 rand oe", {8'h0, pin_oe}, {8'h0, exp_oe(dr, od, dt)});
      chk("R5 R6 rand out", {8'h0, pin_out}, {8'h0, exp_out(od, dt)});
      npins = 24'($urandom);
      if (it % 5 == 0) npins = ~pins;
      ev = ev | exp_hit(pins, npins, ct);
      pins = npins; pin_in = pins;
      repeat (4) @(negedge clk);
      chk("R12 rand irq", {31'h0, irq}, {31'h0, |(ev & mk)});
      rd(5'h08, v); chk("R7 rand data", v, {8'h0, (dr & dt) | (~dr & pins)});
      rd(5'h0C, v); chk("R9 rand event", v, {8'h0, ev});
      c = 24'($urandom);
      wr(5'h0C, {8'hFF, c}); ev = ev & ~c;
      rd(5'h0C, v); chk("R10 rand clear", v, {8'h0, ev});
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule